// File: doc/BRIEF.md
# Tree-Based Task Priority Mediator

The mediator collects one priority bid from each of a fixed number of task slots and names the single slot that should get the processor next. Each slot drives a multi-bit priority and an active flag. A slot with its active flag clear, or with priority zero, does not bid. The slot number of a bid is given only by the input position that carries it. Bids are compared two at a time in a binary tree. The winning slot number, its priority and a valid flag are registered once before they reach a downstream task controller.

The mediator also applies a fairness rule to the task that is running now. The controller names that task with a slot number and a qualifier. The running slot loses its bid while any other active slot at the same priority is requesting, so that its peers get their turn. If it is the only active slot at its level, it keeps its bid. The mediator keeps no task state and makes no switching decision. It only reports the outcome of the bidding.

Top module: `task_bid_mediator`

## Requirements
- R1: While `rst_n` is low, and at the first sampling after it falls, `win_valid`, `win_slot` and `win_prio` are all zero.
- R2: The outputs reflect the inputs sampled at the previous rising clock edge, which is exactly one cycle of latency.
- R3: A slot whose bit in `slot_active` is 0 never wins, whatever priority it drives.
- R4: A priority value of 0 means "not bidding", and such a slot never wins.
- R5: The winner is the slot with the largest effective bid. `win_slot` is its position, where slot k drives bits `slot_prio[k*PRIO_W +: PRIO_W]`, and `win_prio` is the priority that slot drove.
- R6: When several slots share the largest effective bid, the lowest-numbered one wins.
- R7: When no slot has a nonzero effective bid, `win_valid` is 0 and `win_slot` and `win_prio` are 0. Otherwise `win_valid` is 1.
- R8: With `run_valid` high, the slot named by `run_slot` bids zero whenever another active slot drives the same nonzero priority.
- R9: With `run_valid` high, the running slot keeps its bid when no other active slot drives its priority.
- R10: Only the running slot is ever masked. Every other active slot bids its own priority, and with `run_valid` low no slot is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| slot_prio | input | NUM_SLOTS*PRIO_W | Per-slot priority; slot k at bits k*PRIO_W +: PRIO_W |
| slot_active | input | NUM_SLOTS | Per-slot active flag |
| run_valid | input | 1 | A task is running and `run_slot` is meaningful |
| run_slot | input | $clog2(NUM_SLOTS) | Slot number of the running task |
| win_valid | output | 1 | A nonzero winning bid exists |
| win_slot | output | $clog2(NUM_SLOTS) | Slot number of the winner |
| win_prio | output | PRIO_W | Priority of the winner |

## Verification
The bidding is tried with a set of directed patterns, each aimed at one rule:
- A lone bidder shows that the slot number comes from input position alone.
- A high priority on an inactive slot separates the active flag from the priority value.
- Equal top bids at several positions, including the last slot, pin down the lowest-index tie rule.
- Running-task patterns with and without a same-priority peer, and with the qualifier low, tell the masking rule apart from plain priority order.
- A lower-priority bystander in those patterns shows that masking never spreads beyond the running slot.

A long run of pseudo-random bid vectors then covers the tree paths against a model written from the requirements.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
   // true when v is a power of two and at least 2
   function automatic bit tbm_is_pow2(input int unsigned v);
      return (v >= 2) && ((v & (v - 1)) == 0);
   endfunction

   // number of comparator levels for a tree over v leaves
   function automatic int unsigned tbm_levels(input int unsigned v);
      int unsigned n;
      n = 0;
      while ((1 << n) < v) n++;
      return n;
   endfunction
endpackage

// File: rtl/tbm_bid_mask.sv
module tbm_bid_mask #(
   parameter int unsigned NUM_SLOTS = 8,
   parameter int unsigned PRIO_W    = 4,
   localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic [NUM_SLOTS*PRIO_W-1:0] slot_prio,
   input  logic [NUM_SLOTS-1:0]        slot_active,
   input  logic                        run_valid,
   input  logic [IDX_W-1:0]            run_slot,
   output logic [NUM_SLOTS*PRIO_W-1:0] eff_bid
);
   // per-slot flag: another active slot shares this slot's priority
   logic [NUM_SLOTS-1:0] has_peer;
   logic [NUM_SLOTS-1:0] is_running;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      logic [PRIO_W-1:0] own_p;
      assign own_p = slot_prio[s*PRIO_W +: PRIO_W];
      assign is_running[s] = run_valid && (run_slot == IDX_W'(s));

      always_comb begin
         has_peer[s] = 1'b0;
         for (int o = 0; o < NUM_SLOTS; o++) begin
            if (o != s && slot_active[o] &&
                slot_prio[o*PRIO_W +: PRIO_W] == own_p)
               has_peer[s] = 1'b1;
         end
      end

      // inactive slots and a crowded running slot offer nothing
      assign eff_bid[s*PRIO_W +: PRIO_W] =
         (!slot_active[s] || (is_running[s] && has_peer[s])) ? '0 : own_p;
   end
endmodule

// File: rtl/tbm_cmp_node.sv
module tbm_cmp_node #(
   parameter int unsigned PRIO_W = 4,
   parameter int unsigned IDX_W  = 3
) (
   input  logic [PRIO_W-1:0] lo_prio,
   input  logic [IDX_W-1:0]  lo_idx,
   input  logic [PRIO_W-1:0] hi_prio,
   input  logic [IDX_W-1:0]  hi_idx,
   output logic [PRIO_W-1:0] out_prio,
   output logic [IDX_W-1:0]  out_idx
);
   // the upper-index side must be strictly larger to win; ties keep the lower side
   logic take_hi;
   assign take_hi  = hi_prio > lo_prio;
   assign out_prio = take_hi ? hi_prio : lo_prio;
   assign out_idx  = take_hi ? hi_idx  : lo_idx;
endmodule

// File: rtl/tbm_bid_tree.sv
module tbm_bid_tree #(
   parameter int unsigned NUM_SLOTS = 8,
   parameter int unsigned PRIO_W    = 4,
   localparam int unsigned IDX_W    = $clog2(NUM_SLOTS),
   localparam int unsigned LEVELS   = tbm_pkg::tbm_levels(NUM_SLOTS)
) (
   input  logic [NUM_SLOTS*PRIO_W-1:0] eff_bid,
   output logic [PRIO_W-1:0]           root_prio,
   output logic [IDX_W-1:0]            root_idx
);
   // stage l holds NUM_SLOTS >> l candidates, packed side by side
   logic [NUM_SLOTS*PRIO_W-1:0] st_prio [LEVELS+1];
   logic [NUM_SLOTS*IDX_W-1:0]  st_idx  [LEVELS+1];

   assign st_prio[0] = eff_bid;
   for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_leaf
      assign st_idx[0][k*IDX_W +: IDX_W] = IDX_W'(k);
   end

   for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      localparam int unsigned OUTS = NUM_SLOTS >> (l + 1);
      for (genvar n = 0; n < OUTS; n++) begin : g_node
         tbm_cmp_node #(.PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_node (
            .lo_prio  (st_prio[l][(2*n)*PRIO_W   +: PRIO_W]),
            .lo_idx   (st_idx[l][(2*n)*IDX_W     +: IDX_W]),
            .hi_prio  (st_prio[l][(2*n+1)*PRIO_W +: PRIO_W]),
            .hi_idx   (st_idx[l][(2*n+1)*IDX_W   +: IDX_W]),
            .out_prio (st_prio[l+1][n*PRIO_W     +: PRIO_W]),
            .out_idx  (st_idx[l+1][n*IDX_W       +: IDX_W])
         );
      end
      // unused upper part of the narrower stage
      assign st_prio[l+1][NUM_SLOTS*PRIO_W-1:OUTS*PRIO_W] = '0;
      assign st_idx[l+1][NUM_SLOTS*IDX_W-1:OUTS*IDX_W]    = '0;
   end

   assign root_prio = st_prio[LEVELS][PRIO_W-1:0];
   assign root_idx  = st_idx[LEVELS][IDX_W-1:0];
endmodule

// File: rtl/task_bid_mediator.sv
module task_bid_mediator #(
   parameter int unsigned NUM_SLOTS = 8,
   parameter int unsigned PRIO_W    = 4,
   localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_SLOTS*PRIO_W-1:0] slot_prio,
   input  logic [NUM_SLOTS-1:0]        slot_active,
   input  logic                        run_valid,
   input  logic [IDX_W-1:0]            run_slot,
   output logic                        win_valid,
   output logic [IDX_W-1:0]            win_slot,
   output logic [PRIO_W-1:0]           win_prio
);
   if (!tbm_pkg::tbm_is_pow2(NUM_SLOTS)) begin : g_bad_slots
      $error("task_bid_mediator: NUM_SLOTS must be a power of two, at least 2");
   end
   if (PRIO_W < 1) begin : g_bad_prio
      $error("task_bid_mediator: PRIO_W must be at least 1");
   end

   logic [NUM_SLOTS*PRIO_W-1:0] eff_bid;
   logic [PRIO_W-1:0]           root_prio;
   logic [IDX_W-1:0]            root_idx;

   tbm_bid_mask #(.NUM_SLOTS(NUM_SLOTS), .PRIO_W(PRIO_W)) u_mask (
      .slot_prio   (slot_prio),
      .slot_active (slot_active),
      .run_valid   (run_valid),
      .run_slot    (run_slot),
      .eff_bid     (eff_bid)
   );

   tbm_bid_tree #(.NUM_SLOTS(NUM_SLOTS), .PRIO_W(PRIO_W)) u_tree (
      .eff_bid   (eff_bid),
      .root_prio (root_prio),
      .root_idx  (root_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_valid <= 1'b0;
         win_slot  <= '0;
         win_prio  <= '0;
      end else begin
         win_valid <= |root_prio;
         win_slot  <= (|root_prio) ? root_idx : '0;
         win_prio  <= root_prio;
      end
   end
endmodule

// File: rtl/tbm_checker.sv
module tbm_checker #(
   parameter int unsigned NUM_SLOTS = 8,
   parameter int unsigned PRIO_W    = 4,
   localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [NUM_SLOTS*PRIO_W-1:0] slot_prio,
   input logic [NUM_SLOTS-1:0]        slot_active,
   input logic                        run_valid,
   input logic [IDX_W-1:0]            run_slot,
   input logic                        win_valid,
   input logic [IDX_W-1:0]            win_slot,
   input logic [PRIO_W-1:0]           win_prio
);
   // best priority among active slots other than the running one
   logic [PRIO_W-1:0]           bystander_max, bystander_max_q;
   logic [NUM_SLOTS-1:0]        act_q;
   logic [NUM_SLOTS*PRIO_W-1:0] prio_q;

   always_comb begin
      bystander_max = '0;
      for (int k = 0; k < NUM_SLOTS; k++) begin
         if (slot_active[k] && !(run_valid && run_slot == IDX_W'(k)) &&
             slot_prio[k*PRIO_W +: PRIO_W] > bystander_max)
            bystander_max = slot_prio[k*PRIO_W +: PRIO_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q           <= '0;
         prio_q          <= '0;
         bystander_max_q <= '0;
      end else begin
         act_q           <= slot_active;
         prio_q          <= slot_prio;
         bystander_max_q <= bystander_max;
      end
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      !rst_n |=> (!win_valid && win_prio == '0 && win_slot == '0)); // R1

   AST_WINNER_WAS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> act_q[win_slot]); // R3

   AST_WINNER_PRIO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> (win_prio == prio_q[win_slot*PRIO_W +: PRIO_W] && win_prio != '0)); // R5

   AST_IDLE_WHEN_NONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (slot_active == '0) |=> !win_valid); // R7

   AST_BYSTANDER_NOT_BEATEN: assert property (@(posedge clk) disable iff (!rst_n)
      win_prio >= bystander_max_q); // R10
endmodule

bind task_bid_mediator tbm_checker #(.NUM_SLOTS(NUM_SLOTS), .PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/task_bid_mediator_test.sv
module task_bid_mediator_test;
   localparam int N = 8;
   localparam int W = 4;
   localparam int IW = $clog2(N);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N*W-1:0]    slot_prio = '0;
   logic [N-1:0]      slot_active = '0;
   logic              run_valid = 1'b0;
   logic [IW-1:0]     run_slot = '0;
   logic              win_valid;
   logic [IW-1:0]     win_slot;
   logic [W-1:0]      win_prio;

   always #2.5 clk = ~clk;

   task_bid_mediator #(.NUM_SLOTS(N), .PRIO_W(W)) uut (
      .clk, .rst_n, .slot_prio, .slot_active, .run_valid, .run_slot,
      .win_valid, .win_slot, .win_prio
   );

   typedef struct {
      int          due;
      logic        v;
      logic [IW-1:0] s;
      logic [W-1:0]  p;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input string tag, input logic v, input logic [IW-1:0] s,
                        input logic [W-1:0] p, input logic ev,
                        input logic [IW-1:0] es, input logic [W-1:0] ep);
      n_chk++;
      if (v !== ev || s !== es || p !== ep) begin
         n_bad++;
         $display("FAIL %s: got v=%0b slot=%0d prio=%0d, expected v=%0b slot=%0d prio=%0d",
                  tag, v, s, p, ev, es, ep);
      end
   endtask

   // reference model written from the requirements
   task automatic model(output logic ev, output logic [IW-1:0] es, output logic [W-1:0] ep);
      int best_p;
      int best_i;
      best_p = 0;
      best_i = 0;
      for (int i = 0; i < N; i++) begin
         int bid;
         bid = slot_active[i] ? int'(slot_prio[i*W +: W]) : 0;
         if (run_valid && int'(run_slot) == i) begin
            for (int j = 0; j < N; j++)
               if (j != i && slot_active[j] && slot_prio[j*W +: W] == slot_prio[i*W +: W])
                  bid = 0;
         end
         if (bid > best_p) begin
            best_p = bid;
            best_i = i;
         end
      end
      ev = (best_p != 0);
      es = ev ? IW'(best_i) : '0;
      ep = W'(best_p);
   endtask

   // driver: apply one vector after a rising edge and queue its expectation
   task automatic apply(input string tag, input logic [N*W-1:0] pr, input logic [N-1:0] act,
                        input logic rv, input logic [IW-1:0] rs);
      exp_t e;
      @(posedge clk);
      #1;
      slot_prio = pr;
      slot_active = act;
      run_valid = rv;
      run_slot = rs;
      model(e.v, e.s, e.p);
      e.due = cyc + 1;
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   // monitor: compare results once their capture edge has passed
   always @(negedge clk) begin
      while (exp_q.size() > 0 && exp_q[0].due <= cyc) begin
         exp_t e;
         e = exp_q.pop_front();
         check(e.tag, win_valid, win_slot, win_prio, e.v, e.s, e.p);
      end
   end

   function automatic logic [N*W-1:0] pv(input int p0, p1, p2, p3, p4, p5, p6, p7);
      return {W'(p7), W'(p6), W'(p5), W'(p4), W'(p3), W'(p2), W'(p1), W'(p0)};
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      slot_prio = pv(9, 9, 9, 9, 9, 9, 9, 9);
      slot_active = '1;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset state", win_valid, win_slot, win_prio, 1'b0, '0, '0);
      rst_n = 1'b1;
      slot_active = '0;

      apply("R7 nobody active", pv(5, 6, 7, 8, 9, 10, 11, 12), 8'h00, 1'b0, '0);
      apply("R5 R2 lone bidder slot 5", pv(0, 0, 0, 0, 0, 3, 0, 0), 8'h20, 1'b0, '0);
      apply("R5 highest wins", pv(2, 7, 4, 1, 6, 3, 5, 2), 8'hFF, 1'b0, '0);
      apply("R3 inactive high prio ignored", pv(2, 15, 4, 1, 6, 3, 5, 2), 8'hFD, 1'b0, '0);
      apply("R4 zero prio not bidding", pv(0, 0, 0, 0, 0, 0, 0, 0), 8'hFF, 1'b0, '0);
      apply("R6 tie lowest index", pv(1, 4, 2, 9, 3, 9, 0, 9), 8'hFF, 1'b0, '0);
      apply("R6 all equal", pv(6, 6, 6, 6, 6, 6, 6, 6), 8'hFF, 1'b0, '0);
      apply("R5 last slot wins", pv(1, 1, 1, 1, 1, 1, 1, 14), 8'hFF, 1'b0, '0);
      apply("R8 running masked by peer", pv(0, 0, 9, 0, 0, 9, 3, 0), 8'h64, 1'b1, 3'd2);
      apply("R8 running masked lower wins", pv(7, 0, 0, 0, 0, 2, 7, 0), 8'h61, 1'b1, 3'd0);
      apply("R9 running alone at prio", pv(0, 3, 0, 0, 8, 0, 5, 0), 8'h52, 1'b1, 3'd4);
      apply("R9 peer inactive no mask", pv(8, 0, 0, 0, 8, 0, 5, 0), 8'h50, 1'b1, 3'd4);
      apply("R10 run_valid low no mask", pv(0, 0, 9, 0, 0, 9, 3, 0), 8'h64, 1'b0, 3'd2);
      apply("R10 bystander below running", pv(0, 4, 0, 0, 0, 0, 0, 10), 8'h82, 1'b1, 3'd7);
      apply("R8 R6 masked among three", pv(5, 5, 5, 0, 0, 0, 0, 0), 8'h07, 1'b1, 3'd0);
      apply("R7 all masked to zero", pv(0, 0, 0, 0, 0, 0, 0, 0), 8'h00, 1'b1, 3'd1);

      for (int t = 0; t < 400; t++) begin
         apply("R5 random", {$urandom(), $urandom()}, 8'($urandom()),
               1'($urandom()), IW'($urandom()));
      end

      // reset while a winner is presented
      apply("R2 before reset", pv(0, 0, 0, 12, 0, 0, 0, 0), 8'h08, 1'b0, '0);
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b0;
      #1;
      check("R1 async reset clears", win_valid, win_slot, win_prio, 1'b0, '0, '0);
      @(posedge clk);
      #1;
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule